// File: doc/BRIEF.md
# Bidirectional-Bus Universal Shift Register

This block is a parameterised register, eight bits wide by default, that on each rising clock edge either keeps its contents, shifts one place toward the high bit, shifts one place toward the low bit, or takes a whole word from a shared parallel bus. A two-bit operation select picks the action. The same select also sets the bus direction: the load operation turns the bus around so it can be read, and the other three operations let the register drive the bus when both active-low enables are low.

The bus is modelled as three separate signals: an input word, an output word that always shows the register contents, and a per-bit drive enable. A pad ring or bus fabric combines them into a real tri-state line. Both end bits come out on dedicated serial pins that the enables do not gate. Units can therefore be chained: the high-end serial output feeds the next unit's low-end serial input, and the low-end serial output feeds the previous unit's high-end serial input. Looping the last unit's high-end output back to the first unit's low-end input makes the whole chain rotate. The block has no flow control. Each edge consumes the serial and bus inputs of the selected operation, and there is no back-pressure. An active-low clear acts at once, without waiting for a clock.

Top module: `usr_shift_bus`

## Requirements
- R1: While `rst_n` is low, the register is all zeros. This takes effect at once, mid-cycle, and holds through clock edges whatever `sel` and the data inputs are.
- R2: With `sel` = 2'b00 (hold), a clock edge leaves the register unchanged.
- R3: With `sel` = 2'b01 (shift toward the high bit), an edge moves bit i into bit i+1, and `ser_in_lo` enters bit 0.
- R4: With `sel` = 2'b10 (shift toward the low bit), an edge moves bit i into bit i-1, and `ser_in_hi` enters the top bit.
- R5: With `sel` = 2'b11 (load), an edge copies `bus_in` into the register.
- R6: `bus_oe` is all ones when `oe_a_n` and `oe_b_n` are both low and `sel` is not 2'b11. It is all zeros when either enable is high. `bus_out` always equals the register contents.
- R7: With `sel` = 2'b11, `bus_oe` is all zeros even when both enables are low.
- R8: `ser_out_lo` equals register bit 0 and `ser_out_hi` equals the top bit, whatever the state of the enables.
- R9: Two units chained through their serial pins act as one register twice as wide, for shifts in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low clear |
| sel | input | 2 | Operation: 00 hold, 01 shift up, 10 shift down, 11 load |
| ser_in_lo | input | 1 | Serial bit entering bit 0 on a shift up |
| ser_in_hi | input | 1 | Serial bit entering the top bit on a shift down |
| oe_a_n | input | 1 | Bus drive enable A, active low |
| oe_b_n | input | 1 | Bus drive enable B, active low |
| bus_in | input | WIDTH | Word read from the shared bus |
| bus_out | output | WIDTH | Register contents offered to the bus |
| bus_oe | output | WIDTH | Per-bit bus drive enable |
| ser_out_lo | output | 1 | Register bit 0 |
| ser_out_hi | output | 1 | Register top bit |

## Verification
The register updates on the edge that samples `sel`. Its new value appears on `bus_out` and the serial outputs within that same cycle. The bench therefore changes inputs on the falling edge and compares register results at the next falling edge, one edge later. `bus_oe` is purely combinational from `sel` and the enables, so it is compared one time unit after those inputs change, with no clock edge in between. The clear is checked a few time units after `rst_n` falls in mid-cycle, before any edge, and again after an edge taken with load selected.

// File: rtl/usr_pkg.sv
package usr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_SHUP = 2'b01,
    MODE_SHDN = 2'b10,
    MODE_LOAD = 2'b11
  } mode_e;
endpackage

// File: rtl/usr_next_state.sv
module usr_next_state
  import usr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  mode_e             mode,
  input  logic [WIDTH-1:0]  cur,
  input  logic [WIDTH-1:0]  load_val,
  input  logic              ser_lo,
  input  logic              ser_hi,
  output logic [WIDTH-1:0]  nxt
);
  localparam int TOP = WIDTH - 1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic from_below;
    logic from_above;
    if (i == 0) begin : g_lo_edge
      assign from_below = ser_lo;
    end else begin : g_lo_mid
      assign from_below = cur[i-1];
    end
    if (i == TOP) begin : g_hi_edge
      assign from_above = ser_hi;
    end else begin : g_hi_mid
      assign from_above = cur[i+1];
    end
    always_comb begin
      unique case (mode)
        MODE_SHUP: nxt[i] = from_below;
        MODE_SHDN: nxt[i] = from_above;
        MODE_LOAD: nxt[i] = load_val[i];
        default:   nxt[i] = cur[i];
      endcase
    end
  end
endmodule

// File: rtl/usr_bus_ctrl.sv
module usr_bus_ctrl
  import usr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  mode_e             mode,
  input  logic              oe_a_n,
  input  logic              oe_b_n,
  output logic [WIDTH-1:0]  bus_oe
);
  logic enables_on;
  logic mode_drives;

  assign enables_on  = ~(oe_a_n | oe_b_n);
  assign mode_drives = (mode != MODE_LOAD);
  assign bus_oe      = {WIDTH{enables_on & mode_drives}};
endmodule

// File: rtl/usr_shift_bus.sv
module usr_shift_bus
  import usr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        sel,
  input  logic              ser_in_lo,
  input  logic              ser_in_hi,
  input  logic              oe_a_n,
  input  logic              oe_b_n,
  input  logic [WIDTH-1:0]  bus_in,
  output logic [WIDTH-1:0]  bus_out,
  output logic [WIDTH-1:0]  bus_oe,
  output logic              ser_out_lo,
  output logic              ser_out_hi
);
  localparam int TOP = WIDTH - 1;

  mode_e            mode;
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_d;

  assign mode = mode_e'(sel);

  usr_next_state #(.WIDTH(WIDTH)) u_next (
    .mode     (mode),
    .cur      (state_q),
    .load_val (bus_in),
    .ser_lo   (ser_in_lo),
    .ser_hi   (ser_in_hi),
    .nxt      (state_d)
  );

  usr_bus_ctrl #(.WIDTH(WIDTH)) u_bus (
    .mode   (mode),
    .oe_a_n (oe_a_n),
    .oe_b_n (oe_b_n),
    .bus_oe (bus_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end

  assign bus_out    = state_q;
  assign ser_out_lo = state_q[0];
  assign ser_out_hi = state_q[TOP];

  // R1: an edge seen while clear is low leaves the register zero
  a_r1_clear_holds: assert property (@(posedge clk)
    (!rst_n && $past(!rst_n)) |-> (bus_out == '0));

  a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b00) |=> $stable(bus_out));

  a_r3_shift_up: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b01) |=> (ser_out_lo == $past(ser_in_lo)) && (bus_out[TOP:1] == $past(bus_out[TOP-1:0])));

  a_r4_shift_down: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b10) |=> (ser_out_hi == $past(ser_in_hi)) && (bus_out[TOP-1:0] == $past(bus_out[TOP:1])));

  a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b11) |=> (bus_out == $past(bus_in)));

  a_r7_load_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b11) |-> (bus_oe == '0));

  a_r6_enable_off: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_a_n || oe_b_n) |-> (bus_oe == '0));
endmodule

// File: tb/test_usr_shift_bus.sv
module test_usr_shift_bus;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] sel = 2'b00;
  logic sil = 1'b0, sih = 1'b0, oea = 1'b0, oeb = 1'b0;
  logic [W-1:0] bin = '0;
  logic [W-1:0] bout, boe;
  logic sol, soh;

  int total = 0;
  int fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usr_shift_bus #(.WIDTH(W)) i_usr_shift_bus (
    .clk(clk), .rst_n(rst_n), .sel(sel), .ser_in_lo(sil), .ser_in_hi(sih),
    .oe_a_n(oea), .oe_b_n(oeb), .bus_in(bin), .bus_out(bout), .bus_oe(boe),
    .ser_out_lo(sol), .ser_out_hi(soh)
  );

  // chained pair: lo unit holds bits 7..0, hi unit holds bits 15..8
  logic [1:0] c_sel = 2'b00;
  logic c_feed_lo = 1'b0, c_feed_hi = 1'b0;
  logic [W-1:0] c_in_lo = '0, c_in_hi = '0;
  logic [W-1:0] c_out_lo, c_out_hi, c_oe_lo, c_oe_hi;
  logic lo_sol, lo_soh, hi_sol, hi_soh;

  usr_shift_bus #(.WIDTH(W)) i_chain_lo (
    .clk(clk), .rst_n(rst_n), .sel(c_sel), .ser_in_lo(c_feed_lo), .ser_in_hi(hi_sol),
    .oe_a_n(1'b0), .oe_b_n(1'b0), .bus_in(c_in_lo), .bus_out(c_out_lo), .bus_oe(c_oe_lo),
    .ser_out_lo(lo_sol), .ser_out_hi(lo_soh)
  );
  usr_shift_bus #(.WIDTH(W)) i_chain_hi (
    .clk(clk), .rst_n(rst_n), .sel(c_sel), .ser_in_lo(lo_soh), .ser_in_hi(c_feed_hi),
    .oe_a_n(1'b0), .oe_b_n(1'b0), .bus_in(c_in_hi), .bus_out(c_out_hi), .bus_oe(c_oe_hi),
    .ser_out_lo(hi_sol), .ser_out_hi(hi_soh)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one rising edge, then settle to the falling edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) tick();
    chk("R1 reset value", 32'(bout), 32'h00);
    chk("R8 serial outs at reset", {30'd0, soh, sol}, 32'h0);
    rst_n = 1'b1;
    tick();
    chk("R6 drive in hold", 32'(boe), 32'hFF);
  endtask

  task automatic t_load_and_bus();
    sel = 2'b11; bin = 8'hA5; oea = 1'b0; oeb = 1'b0;
    #1 chk("R7 load releases bus", 32'(boe), 32'h00);
    @(negedge clk);
    tick();
    chk("R5 load value", 32'(bout), 32'hA5);
    sel = 2'b00;
    #1 chk("R6 both enables low", 32'(boe), 32'hFF);
    oea = 1'b1;
    #1 chk("R6 enable A high", 32'(boe), 32'h00);
    oea = 1'b0; oeb = 1'b1;
    #1 chk("R6 enable B high", 32'(boe), 32'h00);
    oeb = 1'b0; sel = 2'b10;
    #1 chk("R6 drive in shift", 32'(boe), 32'hFF);
    sel = 2'b00;
    chk("R6 bus_out shows register", 32'(bout), 32'hA5);
  endtask

  task automatic t_hold();
    @(negedge clk);
    sel = 2'b00; bin = 8'h3C; sil = 1'b1; sih = 1'b1;
    repeat (3) tick();
    chk("R2 hold keeps value", 32'(bout), 32'hA5);
  endtask

  task automatic t_shift_up();
    logic [W-1:0] m = 8'hA5;
    logic [W-1:0] pat = 8'b1101_0010;
    sel = 2'b01;
    for (int k = 0; k < W; k++) begin
      sil = pat[k];
      tick();
      m = {m[W-2:0], pat[k]};
      chk("R3 shift up", 32'(bout), 32'(m));
    end
    sel = 2'b00;
  endtask

  task automatic t_shift_down();
    logic [W-1:0] m = bout;
    logic [W-1:0] pat = 8'b0110_1011;
    sel = 2'b10; oea = 1'b1; oeb = 1'b1;
    for (int k = 0; k < W; k++) begin
      sih = pat[k];
      tick();
      m = {pat[k], m[W-1:1]};
      chk("R4 shift down", 32'(bout), 32'(m));
      chk("R8 serial outs with bus off", {30'd0, soh, sol}, {30'd0, m[W-1], m[0]});
    end
    sel = 2'b00; oea = 1'b0; oeb = 1'b0;
  endtask

  task automatic t_async_clear();
    sel = 2'b11; bin = 8'hFF;
    tick();
    chk("R5 load ones", 32'(bout), 32'hFF);
    @(posedge clk);
    #3 rst_n = 1'b0;
    #1 chk("R1 mid-cycle clear", 32'(bout), 32'h00);
    tick();
    chk("R1 clear beats load", 32'(bout), 32'h00);
    @(negedge clk);
    rst_n = 1'b1;
    sel = 2'b00;
    tick();
  endtask

  task automatic t_chain();
    logic [2*W-1:0] m = 16'h1234;
    logic [15:0] pat = 16'hB38E;
    c_sel = 2'b11; c_in_lo = 8'h34; c_in_hi = 8'h12;
    tick();
    chk("R9 chain load", {16'd0, c_out_hi, c_out_lo}, 32'h1234);
    c_sel = 2'b01;
    for (int k = 0; k < 16; k++) begin
      c_feed_lo = pat[k];
      tick();
      m = {m[2*W-2:0], pat[k]};
      chk("R9 chain shift up", {16'd0, c_out_hi, c_out_lo}, {16'd0, m});
    end
    c_sel = 2'b10;
    for (int k = 0; k < 16; k++) begin
      c_feed_hi = pat[15-k];
      tick();
      m = {pat[15-k], m[2*W-1:1]};
      chk("R9 chain shift down", {16'd0, c_out_hi, c_out_lo}, {16'd0, m});
    end
    c_sel = 2'b00;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_load_and_bus();
    t_hold();
    t_shift_up();
    t_shift_down();
    t_async_clear();
    t_chain();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule